// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built from identical 4-bit stages. Each stage counts up or down, takes a parallel load, and clears asynchronously. A stage has two count enables, one for up and one for down. It also has two ripple enable outputs, one for each direction. The ripple enable outputs let stages be chained into a wider counter. Each stage also reports an up terminal count (all ones) and a down terminal count (all zeros).

The top level is a chaining wrapper with a parameter for the number of stages. The external enables drive stage 0. The up and down ripple enables of each stage feed the matching enables of the next stage. Clock, load and clear go to every stage in parallel. The wrapper's terminal counts are the AND of the matching terminal counts of all stages. The wrapper's ripple enables come from the last stage.

The clear is the active-low asynchronous input `rst_ni`. Pulling it low forces the count to zero at once, whatever the clock does.

Top module: `cnt_chain`

## Requirements
- R1: While `rst_ni` is low, `count_o` is zero immediately and stays zero. Clock edges, load and both enables have no effect during this time.
- R2: While `rst_ni` is low, `tc_up_o` is 0 and `tc_dn_o` is 1.
- R3: On a rising clock edge with `load_i` high, `count_o` takes `data_i`. This happens whatever the values of `up_en_i` and `dn_en_i`.
- R4: On a rising edge with `load_i` low, `up_en_i` high and `dn_en_i` low, `count_o` increments by one. It wraps modulo 2^(STAGE_W*N_STAGES), so all ones goes to zero.
- R5: On a rising edge with `load_i` low, `dn_en_i` high and `up_en_i` low, `count_o` decrements by one. It wraps, so zero goes to all ones.
- R6: With `load_i` low and both enables low, clock edges leave `count_o` unchanged.
- R7: A stage whose two enables are both high, with load low, holds its value.
- R8: `tc_up_o` is 1 exactly when `count_o` is all ones, and `tc_dn_o` is 1 exactly when `count_o` is all zeros. Neither output depends on the enables.
- R9: `ceo_up_o` equals (`count_o` all ones AND `up_en_i`). `ceo_dn_o` equals (`count_o` all zeros AND `dn_en_i`).
- R10: The up and down ripple enables of stage k drive the up and down enables of stage k+1. As a result, the chain counts as a single binary counter across all stage boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_i | input | 1 | Parallel load enable |
| data_i | input | STAGE_W*N_STAGES | Load data, stage 0 in the low bits |
| up_en_i | input | 1 | Count-up enable for stage 0 |
| dn_en_i | input | 1 | Count-down enable for stage 0 |
| count_o | output | STAGE_W*N_STAGES | Count value, stage 0 in the low bits |
| tc_up_o | output | 1 | AND of all stage up terminal counts |
| tc_dn_o | output | 1 | AND of all stage down terminal counts |
| ceo_up_o | output | 1 | Up ripple enable of the last stage |
| ceo_dn_o | output | 1 | Down ripple enable of the last stage |

## Verification
Each pattern in the bench targets a different part of the behaviour:
- A full up sweep from zero and a full down sweep from zero pass through every 8-bit value. They cross every nibble boundary and both wrap points, so they separate a correct ripple between stages from a stage that carries or borrows at the wrong moment.
- A load of every value with every mix of enables shows that load wins over counting.
- After each load, a step with both enables low and, where stage 0 is not at a boundary, a step with both enables high tell hold apart from counting.
- A clear asserted in mid-cycle on an all-ones count shows that the clear acts without a clock edge and that the terminal counts take their forced values.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] bits_i,
  output logic         all_o
);
  assign all_o = &bits_i;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         up_en_i,
  input  logic         dn_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         tc_up_o,
  output logic         tc_dn_o,
  output logic         ceo_up_o,
  output logic         ceo_dn_o
);
  import cnt_pkg::*;

  cnt_op_e      op;
  logic [W-1:0] q;

  always_comb begin
    if (load_i) op = OP_LOAD;
    else begin
      unique case ({up_en_i, dn_en_i})
        2'b10:   op = OP_INC;
        2'b01:   op = OP_DEC;
        default: op = OP_HOLD; // both or neither enabled
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else begin
      unique case (op)
        OP_LOAD: q <= data_i;
        OP_INC:  q <= q + 1'b1;
        OP_DEC:  q <= q - 1'b1;
        default: q <= q;
      endcase
    end
  end

  assign count_o  = q;
  assign tc_up_o  = &q;
  assign tc_dn_o  = ~|q;
  assign ceo_up_o = tc_up_o & up_en_i;
  assign ceo_dn_o = tc_dn_o & dn_en_i;

  AST_CLR_ZERO: assert property (@(posedge clk_i) !rst_ni |-> q == '0); // R1
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q == $past(data_i)); // R3
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && up_en_i && !dn_en_i) |=> q == $past(q) + 1'b1); // R4
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dn_en_i && !up_en_i) |=> q == $past(q) - 1'b1); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !up_en_i && !dn_en_i) |=> $stable(q)); // R6
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && up_en_i && dn_en_i) |=> $stable(q)); // R7
  AST_RIPPLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ceo_up_o && ceo_dn_o)); // R9
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int unsigned STAGE_W  = 4,
  parameter int unsigned N_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [STAGE_W*N_STAGES-1:0]   data_i,
  input  logic                          up_en_i,
  input  logic                          dn_en_i,
  output logic [STAGE_W*N_STAGES-1:0]   count_o,
  output logic                          tc_up_o,
  output logic                          tc_dn_o,
  output logic                          ceo_up_o,
  output logic                          ceo_dn_o
);
  localparam int unsigned TOT_W = STAGE_W * N_STAGES;

  logic [N_STAGES:0]   up_rip, dn_rip;
  logic [N_STAGES-1:0] tcu, tcd;

  assign up_rip[0] = up_en_i;
  assign dn_rip[0] = dn_en_i;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .up_en_i  (up_rip[k]),
      .dn_en_i  (dn_rip[k]),
      .data_i   (data_i[k*STAGE_W +: STAGE_W]),
      .count_o  (count_o[k*STAGE_W +: STAGE_W]),
      .tc_up_o  (tcu[k]),
      .tc_dn_o  (tcd[k]),
      .ceo_up_o (up_rip[k+1]),
      .ceo_dn_o (dn_rip[k+1])
    );
  end

  cnt_term #(.N(N_STAGES)) u_tc_up (.bits_i(tcu), .all_o(tc_up_o));
  cnt_term #(.N(N_STAGES)) u_tc_dn (.bits_i(tcd), .all_o(tc_dn_o));

  assign ceo_up_o = up_rip[N_STAGES];
  assign ceo_dn_o = dn_rip[N_STAGES];

  AST_CHAIN_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && up_en_i && !dn_en_i) |=> count_o == $past(count_o) + TOT_W'(1)); // R10
  AST_CHAIN_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dn_en_i && !up_en_i) |=> count_o == $past(count_o) - TOT_W'(1)); // R10
  AST_TC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tc_up_o && tc_dn_o)); // R8
  AST_RIPPLE_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ceo_up_o |-> tc_up_o); // R9
endmodule

// File: tb/cnt_chain_test.sv
module cnt_chain_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       up_en_i = 1'b0;
  logic       dn_en_i = 1'b0;
  logic [7:0] count_o;
  logic       tc_up_o, tc_dn_o, ceo_up_o, ceo_dn_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q = '0;

  cnt_chain #(.STAGE_W(4), .N_STAGES(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
    .up_en_i(up_en_i), .dn_en_i(dn_en_i), .count_o(count_o),
    .tc_up_o(tc_up_o), .tc_dn_o(tc_dn_o), .ceo_up_o(ceo_up_o), .ceo_dn_o(ceo_dn_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_comb(input logic up, input logic dn);
    check("R8 tc_up", int'(tc_up_o), int'(exp_q == 8'hFF));
    check("R8 tc_dn", int'(tc_dn_o), int'(exp_q == 8'h00));
    check("R9 ceo_up", int'(ceo_up_o), int'((exp_q == 8'hFF) && up));
    check("R9 ceo_dn", int'(ceo_dn_o), int'((exp_q == 8'h00) && dn));
  endtask

  // called just after a falling edge
  task automatic step(input string req, input logic ld, input logic [7:0] d,
                      input logic up, input logic dn);
    load_i = ld; data_i = d; up_en_i = up; dn_en_i = dn;
    #1;
    check_comb(up, dn);
    @(posedge clk_i);
    if (ld) exp_q = d;
    else if (up && !dn) exp_q = exp_q + 8'd1;
    else if (dn && !up) exp_q = exp_q - 8'd1;
    @(negedge clk_i);
    check(req, int'(count_o), int'(exp_q));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1/R2: clear held low, load and clocks ignored
    load_i = 1'b1; data_i = 8'hA5; up_en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 count in clear", int'(count_o), 0);
    check("R2 tc_up in clear", int'(tc_up_o), 0);
    check("R2 tc_dn in clear", int'(tc_dn_o), 1);
    rst_ni = 1'b1;
    exp_q = '0;

    // R4/R10: full up sweep with wrap
    step("R3 load zero", 1'b1, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 257; i++) step("R4 R10 up", 1'b0, 8'h00, 1'b1, 1'b0);
    // R5/R10: full down sweep with wrap
    step("R3 load zero", 1'b1, 8'h00, 1'b1, 1'b1);
    for (int i = 0; i < 257; i++) step("R5 R10 down", 1'b0, 8'h00, 1'b0, 1'b1);

    // R3 load over enables, R6/R7 hold
    for (int v = 0; v < 256; v++) begin
      step("R3 load", 1'b1, 8'(v), v[0], v[1]);
      step("R6 idle hold", 1'b0, ~8'(v), 1'b0, 1'b0);
      if (v[3:0] != 4'h0 && v[3:0] != 4'hF)
        step("R7 both hold", 1'b0, ~8'(v), 1'b1, 1'b1);
    end

    // R1/R2: asynchronous clear mid-cycle from all ones
    step("R3 load ones", 1'b1, 8'hFF, 1'b0, 1'b0);
    check("R8 tc_up at ones", int'(tc_up_o), 1);
    @(posedge clk_i);
    #5;
    load_i = 1'b1; data_i = 8'h3C;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", int'(count_o), 0);
    check("R2 tc_up clear", int'(tc_up_o), 0);
    check("R2 tc_dn clear", int'(tc_dn_o), 1);
    @(posedge clk_i);
    #2;
    check("R1 clock ignored in clear", int'(count_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q = '0;
    step("R4 after clear", 1'b0, 8'h00, 1'b1, 1'b0);
    finish_run();
  end
endmodule